// File: doc/BRIEF.md
# BCD Timekeeping Register Bank

This block is a real-time clock that sits at the top eight byte addresses of a small SRAM-style address space. It holds seven packed-BCD time registers (seconds, minutes, hours, day of week, date, month, year) and one control byte. A one-cycle pulse once per second advances the time through a full calendar cascade, with month lengths and a leap year every fourth year. Any bit that is not part of a counting field is plain storage: it keeps what the host writes and reads back unchanged.

The host reaches the registers through an active-low chip-enable / write-enable / output-enable port. The data bus is split into an input byte, an output byte and an output-drive flag. The time is controlled by three bits. A stop bit in the seconds byte halts counting. A write-freeze bit in the control byte suspends tick updates while software loads a new time. A read-freeze bit in the control byte makes reads return a coherent snapshot while counting goes on underneath. A frequency-test bit in the day byte makes a test output toggle at a divided rate of the tick.

Top module: `rtc_regbank`

## Requirements
- R1: After a synchronous active-low reset, the offsets read control 0x00, seconds 0x00, minutes 0x00, hours 0x00, day 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Only addresses whose bits above bit 2 are all ones are decoded. Address bits [2:0] select control (0), seconds (1), minutes (2), hours (3), day (4), date (5), month (6) and year (7). Any other address never drives the bus and never changes a register.
- R3: The output byte is driven, and the drive flag is high, only while chip enable is low, write enable is high and output enable is low inside the window. The output byte is 0x00 whenever it is not driven.
- R4: On each rising clock edge where chip enable and write enable are both low inside the window, the addressed byte takes the input byte. While write enable is low the drive flag stays low, even with output enable low.
- R5: The counting fields are masked as seconds 0x7F, minutes 0x7F, hours 0x3F, day 0x07, date 0x3F, month 0x1F and year 0xFF. The control byte has no counting field. All other bits keep the value written and are never changed by a tick.
- R6: On an accepted tick, seconds count 00 to 59 and minutes 00 to 59, and hours count 00 to 23. Each field carries into the next one when it wraps. A field already at or above its limit wraps on the advance.
- R7: An hour wrap advances day of week 01 to 07 (wrapping to 01) and the date. The date wraps to 01 after 28 or 29 in month 02, after 30 in months 04, 06, 09 and 11, and after 31 otherwise. Month 02 has 29 days when the year value is a multiple of four. A date wrap advances the month (12 wraps to 01), and a month wrap advances the year (99 wraps to 00).
- R8: While seconds bit 7 (stop) is set, ticks change no time register.
- R9: While control bit 7 (write freeze) is set, ticks change no time register. Host writes still land, and counting resumes from the loaded values once the bit clears.
- R10: While control bit 6 (read freeze) is set, reads of offsets 1 to 7 return the time as it stood when the bit was set, and counting continues underneath. Once the bit clears, reads return the live time.
- R11: While day bit 6 (frequency test) is set and the stop bit is clear, the test output toggles on every FT_DIV-th tick, starting from low. At any other time it is low one edge after the condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| ce_n_i | input | 1 | Chip enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Byte address |
| din_i | input | 8 | Write data |
| dout_o | output | 8 | Read data, 0x00 when not driven |
| dout_en_o | output | 1 | High while the read data is driven |
| ftest_o | output | 1 | Frequency-test output |

## Verification
Reads are combinational from the register bank, so the bench drives a read on the falling edge and samples the bus 1 ns later, with no clock edge in between. Host writes and tick advances land on the rising edge that samples them. Their effect is sampled 1 ns after that edge, or by a read in a later low phase. The test output changes on the edge of the FT_DIV-th accepted tick and clears one edge after its enable drops, and the bench waits that one extra edge before checking the clear. Expected bytes come from a bench calendar model worked in binary. The model is driven by directed rollover cases and by a seeded random mix of writes, ticks and reads.

// File: rtl/rtc_pkg.sv
// rtc_pkg: shared types, register offsets and field helpers for the
// timekeeping register bank. Assumes packed BCD, two digits per byte.
package rtc_pkg;

    typedef logic [7:0] byte_t;

    localparam int unsigned NREG      = 8;
    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_SEC   = 1;
    localparam int unsigned IDX_MIN   = 2;
    localparam int unsigned IDX_HOUR  = 3;
    localparam int unsigned IDX_DAY   = 4;
    localparam int unsigned IDX_DATE  = 5;
    localparam int unsigned IDX_MONTH = 6;
    localparam int unsigned IDX_YEAR  = 7;

    // Bits of each byte that belong to the counting field.
    function automatic byte_t field_mask(int unsigned i);
        case (i)
            IDX_SEC, IDX_MIN: return 8'h7F;
            IDX_HOUR:         return 8'h3F;
            IDX_DAY:          return 8'h07;
            IDX_DATE:         return 8'h3F;
            IDX_MONTH:        return 8'h1F;
            IDX_YEAR:         return 8'hFF;
            default:          return 8'h00;
        endcase
    endfunction

    // First value of each field after a wrap.
    function automatic byte_t field_low(int unsigned i);
        case (i)
            IDX_DAY, IDX_DATE, IDX_MONTH: return 8'h01;
            default:                      return 8'h00;
        endcase
    endfunction

    // Last value of each field; the date limit is replaced at run time.
    function automatic byte_t field_high(int unsigned i);
        case (i)
            IDX_SEC, IDX_MIN: return 8'h59;
            IDX_HOUR:         return 8'h23;
            IDX_DAY:          return 8'h07;
            IDX_DATE:         return 8'h31;
            IDX_MONTH:        return 8'h12;
            IDX_YEAR:         return 8'h99;
            default:          return 8'h00;
        endcase
    endfunction

    // Field whose wrap advances field i.
    function automatic int unsigned carry_source(int unsigned i);
        case (i)
            IDX_MIN:            return IDX_SEC;
            IDX_HOUR:           return IDX_MIN;
            IDX_DAY, IDX_DATE:  return IDX_HOUR;
            IDX_MONTH:          return IDX_DATE;
            IDX_YEAR:           return IDX_MONTH;
            default:            return IDX_CTRL;
        endcase
    endfunction

    // Reset contents of each byte.
    function automatic byte_t reset_value(int unsigned i);
        return field_low(i);
    endfunction

    // Two-digit BCD increment without range check.
    function automatic byte_t bcd_inc(byte_t v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    // Last date of a month in BCD, leap year every fourth year.
    function automatic byte_t month_days(byte_t month, byte_t year);
        logic [7:0] ybin;
        ybin = {4'd0, year[7:4]} * 8'd10 + {4'd0, year[3:0]};
        case (month)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_host_port.sv
// rtc_host_port: decodes the active-low host strobes into a register
// index, a write strobe and a read-drive flag. Assumes the clock window
// is the top 2**IDX_W byte addresses; everything else belongs elsewhere.
module rtc_host_port #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned IDX_W  = 3
) (
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic              wr_stb_o,
    output logic              rd_drive_o
);

    logic in_window;

    // Window hit, offset and strobe decode.
    always_comb begin
        in_window  = &addr_i[ADDR_W-1:IDX_W];
        idx_o      = addr_i[IDX_W-1:0];
        wr_stb_o   = in_window && !ce_n_i && !we_n_i;
        rd_drive_o = in_window && !ce_n_i && we_n_i && !oe_n_i;
    end

endmodule

// File: rtl/rtc_bcd_field.sv
// rtc_bcd_field: next-value logic for one BCD counting field. Assumes the
// caller has masked away free bits; a value at or above hi_i wraps.
module rtc_bcd_field
    import rtc_pkg::*;
(
    input  byte_t cur_i,
    input  logic  inc_i,
    input  byte_t lo_i,
    input  byte_t hi_i,
    output byte_t nxt_o,
    output logic  wrap_o
);

    logic at_top;

    // Hold, wrap to the low bound, or count up by one.
    always_comb begin
        at_top = (cur_i >= hi_i);
        wrap_o = inc_i && at_top;
        if (!inc_i)      nxt_o = cur_i;
        else if (at_top) nxt_o = lo_i;
        else             nxt_o = bcd_inc(cur_i);
    end

endmodule

// File: rtl/rtc_freq_test.sv
// rtc_freq_test: divides accepted ticks for the frequency-test output.
// Assumes en_i already folds in the test bit and the oscillator state.
module rtc_freq_test #(
    parameter int unsigned DIV = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic tick_i,
    output logic ft_o
);

    localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count ticks while enabled; toggle at the end of each run of DIV ticks.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i || !en_i) begin
            cnt_q <= '0;
            ft_o  <= 1'b0;
        end else if (tick_i) begin
            if (cnt_q == LAST) begin
                cnt_q <= '0;
                ft_o  <= !ft_o;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rtc_regbank.sv
// rtc_regbank: eight-byte BCD timekeeping bank with host access, a stop
// bit, write and read freeze bits and a frequency-test output. Assumes
// tick_i is a single-cycle pulse synchronous to clk_i.
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned FT_DIV = 4
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              tick_i,
    input  logic              ce_n_i,
    input  logic              we_n_i,
    input  logic              oe_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        din_i,
    output logic [7:0]        dout_o,
    output logic              dout_en_o,
    output logic              ftest_o
);

    localparam int unsigned IDX_W  = $clog2(NREG);
    localparam int unsigned TIME_W = 8 * (NREG - 1);

    byte_t live_q [NREG];
    byte_t snap_q [NREG];
    byte_t nxt    [NREG];
    byte_t rd_val [NREG];
    logic  wrap   [NREG];
    logic  inc    [NREG];

    logic [IDX_W-1:0]  idx;
    logic              wr_stb;
    logic              rd_drive;
    logic              wbit, rbit, stop_bit, ft_bit, advance;
    byte_t             month_len;
    byte_t             rd_byte;
    logic [TIME_W-1:0] time_flat;
    logic [TIME_W-1:0] snap_flat;

    rtc_host_port #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_port (
        .ce_n_i     (ce_n_i),
        .we_n_i     (we_n_i),
        .oe_n_i     (oe_n_i),
        .addr_i     (addr_i),
        .idx_o      (idx),
        .wr_stb_o   (wr_stb),
        .rd_drive_o (rd_drive)
    );

    // Control bits and the tick qualifier.
    always_comb begin
        wbit      = live_q[IDX_CTRL][7];
        rbit      = live_q[IDX_CTRL][6];
        stop_bit  = live_q[IDX_SEC][7];
        ft_bit    = live_q[IDX_DAY][6];
        advance   = tick_i && !stop_bit && !wbit;
        month_len = month_days(live_q[IDX_MONTH] & field_mask(IDX_MONTH),
                               live_q[IDX_YEAR] & field_mask(IDX_YEAR));
    end

    // One counting field per time byte, chained through the carry map.
    for (genvar g = 0; g < NREG; g++) begin : g_field
        if (g == IDX_CTRL) begin : g_ctrl
            assign inc[g]    = 1'b0;
            assign wrap[g]   = 1'b0;
            assign nxt[g]    = live_q[g];
            assign rd_val[g] = live_q[g];
        end else begin : g_time
            if (g == IDX_SEC) begin : g_first
                assign inc[g] = advance;
            end else begin : g_chain
                assign inc[g] = wrap[carry_source(g)];
            end
            rtc_bcd_field u_cnt (
                .cur_i  (live_q[g] & field_mask(g)),
                .inc_i  (inc[g]),
                .lo_i   (field_low(g)),
                .hi_i   ((g == IDX_DATE) ? month_len : field_high(g)),
                .nxt_o  (nxt[g]),
                .wrap_o (wrap[g])
            );
            assign rd_val[g]                = rbit ? snap_q[g] : live_q[g];
            assign time_flat[(g-1)*8 +: 8] = live_q[g];
            assign snap_flat[(g-1)*8 +: 8] = snap_q[g];
        end
    end

    // Live bank: tick updates touch field bits only; host writes win.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < NREG; i++) live_q[i] <= reset_value(i);
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (advance)
                    live_q[i] <= (live_q[i] & ~field_mask(i)) | (nxt[i] & field_mask(i));
                if (wr_stb && idx == IDX_W'(i))
                    live_q[i] <= din_i;
            end
        end
    end

    // Snapshot follows the live bank until the read-freeze bit is set.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < NREG; i++) snap_q[i] <= reset_value(i);
        end else if (!rbit) begin
            for (int i = 0; i < NREG; i++) snap_q[i] <= live_q[i];
        end
    end

    // Read mux and bus drive.
    always_comb begin
        rd_byte   = rd_val[idx];
        dout_en_o = rd_drive;
        dout_o    = rd_drive ? rd_byte : 8'h00;
    end

    rtc_freq_test #(
        .DIV (FT_DIV)
    ) u_ft (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .en_i    (ft_bit && !stop_bit),
        .tick_i  (tick_i),
        .ft_o    (ftest_o)
    );

endmodule

// File: rtl/rtc_regbank_chk.sv
// rtc_regbank_chk: temporal checks on the timekeeping bank, bound to
// every instance of rtc_regbank.
module rtc_regbank_chk #(
    parameter int unsigned TIME_W = 56
) (
    input logic              clk_i,
    input logic              rst_n_i,
    input logic              tick_i,
    input logic              ce_n_i,
    input logic              we_n_i,
    input logic              oe_n_i,
    input logic              dout_en_o,
    input logic              ftest_o,
    input logic              wr_stb,
    input logic              wbit,
    input logic              rbit,
    input logic              stop_bit,
    input logic              ft_bit,
    input logic [TIME_W-1:0] time_flat,
    input logic [TIME_W-1:0] snap_flat
);

    a_r3_drive_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        dout_en_o |-> (!ce_n_i && we_n_i && !oe_n_i));

    a_r4_write_mutes_bus: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !we_n_i |-> !dout_en_o);

    a_r8_stop_holds_time: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (stop_bit && !wr_stb) |=> $stable(time_flat));

    a_r9_write_freeze_holds: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (wbit && !wr_stb) |=> $stable(time_flat));

    a_r10_snapshot_frozen: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rbit |=> $stable(snap_flat));

    a_r11_ftest_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(ft_bit && !stop_bit) |=> !ftest_o);

    a_r11_ftest_on_tick: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (ft_bit && !stop_bit && !tick_i) |=> $stable(ftest_o));

endmodule

bind rtc_regbank rtc_regbank_chk #(.TIME_W(TIME_W)) u_chk (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .tick_i    (tick_i),
    .ce_n_i    (ce_n_i),
    .we_n_i    (we_n_i),
    .oe_n_i    (oe_n_i),
    .dout_en_o (dout_en_o),
    .ftest_o   (ftest_o),
    .wr_stb    (wr_stb),
    .wbit      (wbit),
    .rbit      (rbit),
    .stop_bit  (stop_bit),
    .ft_bit    (ft_bit),
    .time_flat (time_flat),
    .snap_flat (snap_flat)
);

// File: tb/rtc_regbank_test.sv
// rtc_regbank_test: directed and seeded random checks of the bank
// against a binary calendar model kept in the bench.
module rtc_regbank_test;

    localparam int unsigned ADDR_W = 15;
    localparam int unsigned FT_DIV = 4;
    localparam logic [ADDR_W-4:0] WIN = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic              ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic              dout_en, ftest;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] mdl  [8];
    logic [7:0] snap [8];

    always #4 clk = !clk;   // 125 MHz

    rtc_regbank #(.ADDR_W(ADDR_W), .FT_DIV(FT_DIV)) uut (
        .clk_i(clk), .rst_n_i(rst_n), .tick_i(tick),
        .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
        .addr_i(addr), .din_i(din), .dout_o(dout),
        .dout_en_o(dout_en), .ftest_o(ftest)
    );

    function automatic logic [7:0] fmask(int i);
        case (i)
            1, 2:    return 8'h7F;
            3, 5:    return 8'h3F;
            4:       return 8'h07;
            6:       return 8'h1F;
            7:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic int b2i(logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic void put(int i, int n);
        mdl[i] = (mdl[i] & ~fmask(i)) | (i2b(n) & fmask(i));
    endfunction

    // Calendar model worked in binary.
    function automatic void model_tick();
        int s, mi, h, dw, dt, mo, yr, last;
        if (mdl[0][7] || mdl[1][7]) return;
        s  = b2i(mdl[1] & 8'h7F); mi = b2i(mdl[2] & 8'h7F); h = b2i(mdl[3] & 8'h3F);
        dw = b2i(mdl[4] & 8'h07); dt = b2i(mdl[5] & 8'h3F);
        mo = b2i(mdl[6] & 8'h1F); yr = b2i(mdl[7]);
        if (s < 59) s++;
        else begin
            s = 0;
            if (mi < 59) mi++;
            else begin
                mi = 0;
                if (h < 23) h++;
                else begin
                    h = 0;
                    dw = (dw >= 7) ? 1 : dw + 1;
                    if (mo == 2) last = (yr % 4 == 0) ? 29 : 28;
                    else if (mo == 4 || mo == 6 || mo == 9 || mo == 11) last = 30;
                    else last = 31;
                    if (dt < last) dt++;
                    else begin
                        dt = 1;
                        if (mo < 12) mo++;
                        else begin
                            mo = 1;
                            yr = (yr >= 99) ? 0 : yr + 1;
                        end
                    end
                end
            end
        end
        put(1, s); put(2, mi); put(3, h); put(4, dw); put(5, dt); put(6, mo); put(7, yr);
    endfunction

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(int idx, logic [7:0] v);
        @(negedge clk);
        addr = {WIN, 3'(idx)}; din = v; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1;
        if (!mdl[0][6]) snap = mdl;
        mdl[idx] = v;
    endtask

    task automatic rd(int idx, string tag);
        logic [7:0] e;
        e = (mdl[0][6] && idx != 0) ? snap[idx] : mdl[idx];
        @(negedge clk);
        addr = {WIN, 3'(idx)}; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
        #1;
        chk(tag, {7'd0, dout_en}, 8'd1);
        chk(tag, dout, e);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_all(string tag);
        for (int i = 0; i < 8; i++) rd(i, tag);
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(posedge clk); #1; tick = 1'b0;
        model_tick();
    endtask

    task automatic load(int yr, int mo, int dt, int dw, int h, int mi, int s);
        wr(7, i2b(yr)); wr(6, i2b(mo)); wr(5, i2b(dt)); wr(4, i2b(dw));
        wr(3, i2b(h));  wr(2, i2b(mi)); wr(1, i2b(s));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) mdl[i] = (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
        snap = mdl;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset contents
        rd_all("R1 reset");
        chk("R11 reset ftest", {7'd0, ftest}, 8'd0);

        // R5 free bits are storage and survive a tick
        wr(2, 8'hB4); wr(3, 8'hD2); wr(4, 8'hB9); wr(5, 8'hC5); wr(6, 8'hE9); wr(0, 8'h3F);
        rd_all("R5 free bits");
        do_tick();
        rd_all("R5 free bits after tick");
        wr(0, 8'h00);

        // R6 R7 rollover cascades
        load(23, 2, 28, 7, 23, 59, 59); do_tick(); rd_all("R7 feb28 common year");
        load(24, 2, 28, 3, 23, 59, 59); do_tick(); rd_all("R7 feb28 leap year");
        do_tick(); rd_all("R6 plain second");
        load(24, 2, 29, 4, 23, 59, 59); do_tick(); rd_all("R7 feb29 leap year");
        load(99, 12, 31, 5, 23, 59, 59); do_tick(); rd_all("R7 year wrap");
        load(10, 4, 30, 6, 23, 59, 59); do_tick(); rd_all("R7 thirty-day month");
        load(10, 5, 30, 6, 12, 34, 59); do_tick(); rd_all("R6 minute carry");

        // R8 stop bit
        wr(1, 8'h90);
        repeat (3) do_tick();
        rd(1, "R8 stopped");
        wr(1, 8'h10); do_tick(); rd(1, "R8 resumed");

        // R9 write freeze
        wr(0, 8'h80); do_tick(); do_tick(); rd_all("R9 frozen");
        wr(1, 8'h45); rd(1, "R9 write while frozen");
        wr(0, 8'h00); do_tick(); rd_all("R9 resumed");

        // R10 read freeze
        wr(0, 8'h40);
        repeat (3) do_tick();
        rd_all("R10 snapshot");
        wr(0, 8'h00); rd_all("R10 live again");

        // R3 R4 bus rules
        @(negedge clk);
        addr = {WIN, 3'd1}; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; #1;
        chk("R3 oe high no drive", {7'd0, dout_en}, 8'd0);
        chk("R3 undriven bus zero", dout, 8'h00);
        ce_n = 1'b1; oe_n = 1'b0; #1;
        chk("R3 ce high no drive", {7'd0, dout_en}, 8'd0);
        oe_n = 1'b1;
        @(negedge clk);
        addr = {WIN, 3'd2}; din = 8'h17; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; #1;
        chk("R4 write mutes bus", {7'd0, dout_en}, 8'd0);
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        mdl[2] = 8'h17;
        rd(2, "R4 write landed");

        // R2 outside the window
        @(negedge clk);
        addr = 15'h7FF1; ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; #1;
        chk("R2 outside read no drive", {7'd0, dout_en}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        addr = 15'h0001; din = 8'h33; ce_n = 1'b0; we_n = 1'b0;
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1;
        rd(1, "R2 outside write ignored");

        // R11 frequency test output
        wr(4, 8'h41);
        for (int k = 1; k <= 12; k++) begin
            do_tick();
            chk("R11 ftest toggle", {7'd0, ftest},
                {7'd0, ((k >= 4 && k < 8) || k >= 12) ? 1'b1 : 1'b0});
        end
        wr(1, 8'h80);
        @(posedge clk); #1;
        chk("R11 ftest cleared by stop", {7'd0, ftest}, 8'd0);
        wr(1, 8'h00); wr(4, 8'h01);

        // R6 R7 random mix against the model
        for (int n = 0; n < 400; n++) begin
            int op, i, lo, span;
            logic [7:0] v;
            op = int'($urandom % 4);
            if (op == 0) begin
                i = 1 + int'($urandom % 7);
                case (i)
                    1, 2:    begin lo = 0; span = 60;  end
                    3:       begin lo = 0; span = 24;  end
                    4:       begin lo = 1; span = 7;   end
                    5:       begin lo = 1; span = 31;  end
                    6:       begin lo = 1; span = 12;  end
                    default: begin lo = 0; span = 100; end
                endcase
                v = (i2b(lo + int'($urandom % span)) & fmask(i)) | (8'($urandom) & ~fmask(i));
                if (i == 1) v[7] = ($urandom % 4 == 0);
                wr(i, v);
            end else if (op == 3) begin
                rd(int'($urandom % 8), "R6 R7 random read");
            end else begin
                do_tick();
            end
        end
        wr(1, 8'h58);
        repeat (3) do_tick();
        rd_all("R6 R7 random final");

        finish_run();
    end

endmodule